// File: doc/BRIEF.md
# Steered Priority Interrupt Controller

The block gathers a large set of interrupt sources and presents one winning interrupt to each of two targets: a main CPU and an I/O coprocessor. Each source holds a 4-bit priority and a steering bit that chooses its target. For each target, the block picks the pending source with the highest priority that is above that target's current priority. It reports the winner as a 9-bit vector equal to the source index and raises a request line. The lowest eight source indices are software flags. The highest indices are reserved and never request.

A small write port configures the block. Through it, software sets source priorities and steering, sets and clears the software flags, and rewrites either target's current priority. Rewriting the current priority lets software raise a target's ceiling while it holds a shared resource.

Each target has an acknowledge and an end-of-interrupt strobe. Acknowledge saves the current priority on a 16-deep stack and raises the current priority to the winner's level. End-of-interrupt restores the saved level. A separate critical input passes straight to the CPU's critical line.

Top module: `intc_steer_top`

## Requirements
- R1: After synchronous reset, both request outputs are 0, both current priorities are 0 and both stacks are empty. All priorities, steering bits and software flags are 0.
- R2: A target's vector output equals the index of the winning source. Request and vector are registered, so a change on irq_i appears after the next rising edge. A configuration write appears one edge after the write is taken.
- R3: Among eligible sources, the highest priority wins, with 15 the highest level. At equal priority, the lowest source index wins.
- R4: Configuration write (cfg_sel_i = 0) sets the addressed source's priority from cfg_wdata_i[3:0] and its steering from cfg_wdata_i[4]. Steering 0 routes the source to the CPU and 1 to the coprocessor. A source requests only on its own target, and priority levels have the same meaning on both targets.
- R5: A target requests only when the winner's priority is strictly greater than that target's current priority. cfg_sel_i = 2 writes the CPU's current priority from cfg_wdata_i[3:0], and cfg_sel_i = 3 writes the coprocessor's.
- R6: Sources 0 to 7 are pending only while their software flag is set, and irq_i bits 0 to 7 are ignored. cfg_sel_i = 1 with cfg_idx_i below 8 writes cfg_wdata_i[0] into that flag.
- R7: The top 22 source indices (294 to 315 by default) never raise a request, whatever their input and priority.
- R8: An acknowledge while the target's request is high does two things at the acknowledging edge. It pushes the old current priority and replaces it with the winner's priority. An acknowledge while the request is low has no effect.
- R9: End-of-interrupt pops the stack into the current priority. End-of-interrupt on an empty stack has no effect.
- R10: crit_i drives cpu_crit_o combinationally in the same cycle.
- R11: An acknowledge while the stack holds 16 entries has no effect. In the same cycle, a current-priority write takes precedence over acknowledge, and acknowledge takes precedence over end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | N_SRC | Level interrupt requests, one per source |
| crit_i | input | 1 | Critical external interrupt |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write kind: 0 source, 1 software flag, 2 CPU current priority, 3 coprocessor current priority |
| cfg_idx_i | input | 9 | Source index for kinds 0 and 1 |
| cfg_wdata_i | input | 5 | Write data |
| cpu_ack_i | input | 1 | CPU acknowledge strobe |
| cpu_eoi_i | input | 1 | CPU end-of-interrupt strobe |
| iop_ack_i | input | 1 | Coprocessor acknowledge strobe |
| iop_eoi_i | input | 1 | Coprocessor end-of-interrupt strobe |
| cpu_req_o | output | 1 | CPU interrupt request |
| cpu_vec_o | output | 9 | CPU winning vector |
| cpu_cur_prio_o | output | 4 | CPU current priority |
| cpu_crit_o | output | 1 | CPU critical interrupt line |
| iop_req_o | output | 1 | Coprocessor interrupt request |
| iop_vec_o | output | 9 | Coprocessor winning vector |
| iop_cur_prio_o | output | 4 | Coprocessor current priority |

## Verification
Each result is due at a fixed number of cycles after its stimulus:
- An irq_i change shows on request and vector one rising edge later.
- A configuration write shows one edge after the edge that takes it.
- Acknowledge and end-of-interrupt change the current-priority output at their own edge and the request one edge later.
- The critical line follows in the same cycle.

The bench drives inputs just after a rising edge and waits exactly those edges before it compares. In the directed latency case, it also samples once before the due edge to confirm the old value still stands.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int PRIO_W  = 4;
    localparam int VEC_W   = 9;
    localparam int N_TGT   = 2;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef enum logic [1:0] {
        SEL_SRC     = 2'd0,
        SEL_SWF     = 2'd1,
        SEL_CUR_CPU = 2'd2,
        SEL_CUR_IOP = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic  valid;
        prio_t prio;
        vec_t  vec;
    } win_t;

    // candidate replaces the running best only on a strictly higher level,
    // which leaves the lowest index in place on a tie
    function automatic logic outranks(prio_t cand, logic have, prio_t best);
        return !have || (cand > best);
    endfunction

endpackage

// File: rtl/intc_src_cfg.sv
module intc_src_cfg
    import intc_pkg::*;
#(
    parameter int N_SRC = 316,
    parameter int N_RSV = 22,
    parameter int N_SW  = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_SRC-1:0]              irq_i,
    input  logic                          we_i,
    input  logic [1:0]                    sel_i,
    input  vec_t                          idx_i,
    input  logic [PRIO_W:0]               wdata_i,
    output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o,
    output logic [N_SRC-1:0]              tgt_o,
    output logic [N_SRC-1:0]              pend_o
);
    localparam int N_LIVE = N_SRC - N_RSV;
    localparam int SWW    = (N_SW > 1) ? $clog2(N_SW) : 1;

    logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [N_SRC-1:0]             tgt_q;
    logic [N_SW-1:0]              swf_q;
    logic                         unused_irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            tgt_q  <= '0;
            swf_q  <= '0;
        end else if (we_i) begin
            if (sel_i == SEL_SRC && int'(idx_i) < N_SRC) begin
                prio_q[idx_i] <= wdata_i[PRIO_W-1:0];
                tgt_q[idx_i]  <= wdata_i[PRIO_W];
            end
            if (sel_i == SEL_SWF && int'(idx_i) < N_SW) begin
                swf_q[idx_i[SWW-1:0]] <= wdata_i[0];
            end
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_pend
        if (g < N_SW) begin : g_sw
            assign pend_o[g] = swf_q[g];
        end else if (g >= N_LIVE) begin : g_rsv
            assign pend_o[g] = 1'b0;
        end else begin : g_hw
            assign pend_o[g] = irq_i[g];
        end
    end

    assign unused_irq = ^irq_i;
    assign prio_o     = prio_q;
    assign tgt_o      = tgt_q;

endmodule

// File: rtl/intc_arb.sv
module intc_arb
    import intc_pkg::*;
#(
    parameter int N_SRC   = 316,
    parameter bit TGT_BIT = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_SRC-1:0]              pend_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_i,
    input  logic [N_SRC-1:0]              tgt_i,
    input  prio_t                         cur_i,
    output win_t                          win_o
);
    win_t nxt, win_q;

    always_comb begin
        nxt = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend_i[i] && (tgt_i[i] == TGT_BIT) && (prio_i[i] > cur_i)
                && outranks(prio_i[i], nxt.valid, nxt.prio)) begin
                nxt.valid = 1'b1;
                nxt.prio  = prio_i[i];
                nxt.vec   = vec_t'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= nxt;
    end

    assign win_o = win_q;

endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack
    import intc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_cur_i,
    input  prio_t         wr_val_i,
    input  logic          ack_i,
    input  logic          eoi_i,
    input  win_t          win_i,
    output prio_t         cur_o,
    output logic [DW-1:0] depth_o
);
    prio_t         mem_q [DEPTH];
    prio_t         cur_q;
    logic [DW-1:0] depth_q;
    logic          full, do_push, do_pop;
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign full    = (depth_q == DW'(DEPTH));
    assign wr_ptr  = depth_q[AW-1:0];
    assign rd_ptr  = AW'(depth_q - 1'b1);
    assign do_push = !wr_cur_i && ack_i && win_i.valid && !full;
    assign do_pop  = !wr_cur_i && !ack_i && eoi_i && (depth_q != '0);

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr] <= cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            depth_q <= '0;
        end else if (wr_cur_i) begin
            cur_q <= wr_val_i;
        end else if (do_push) begin
            cur_q   <= win_i.prio;
            depth_q <= depth_q + 1'b1;
        end else if (do_pop) begin
            cur_q   <= mem_q[rd_ptr];
            depth_q <= depth_q - 1'b1;
        end
    end

    assign cur_o   = cur_q;
    assign depth_o = depth_q;

endmodule

// File: rtl/intc_steer_top.sv
module intc_steer_top
    import intc_pkg::*;
#(
    parameter int N_SRC     = 316,
    parameter int N_RSV     = 22,
    parameter int N_SW      = 8,
    parameter int STK_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_i,
    input  logic              crit_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [8:0]        cfg_idx_i,
    input  logic [4:0]        cfg_wdata_i,
    input  logic              cpu_ack_i,
    input  logic              cpu_eoi_i,
    input  logic              iop_ack_i,
    input  logic              iop_eoi_i,
    output logic              cpu_req_o,
    output logic [8:0]        cpu_vec_o,
    output logic [3:0]        cpu_cur_prio_o,
    output logic              cpu_crit_o,
    output logic              iop_req_o,
    output logic [8:0]        iop_vec_o,
    output logic [3:0]        iop_cur_prio_o
);
    localparam int DW = $clog2(STK_DEPTH + 1);

    logic [N_SRC-1:0][PRIO_W-1:0] prio_tab;
    logic [N_SRC-1:0]             tgt_tab;
    logic [N_SRC-1:0]             pend;
    logic [N_TGT-1:0]             ack_v, eoi_v, wr_cur_v;
    win_t                         win   [N_TGT];
    prio_t                        cur   [N_TGT];
    logic [DW-1:0]                stk_depth [N_TGT];

    assign ack_v    = {iop_ack_i, cpu_ack_i};
    assign eoi_v    = {iop_eoi_i, cpu_eoi_i};
    assign wr_cur_v = {cfg_we_i && (cfg_sel_i == SEL_CUR_IOP),
                       cfg_we_i && (cfg_sel_i == SEL_CUR_CPU)};

    intc_src_cfg #(.N_SRC(N_SRC), .N_RSV(N_RSV), .N_SW(N_SW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .irq_i   (irq_i),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_i),
        .idx_i   (cfg_idx_i),
        .wdata_i (cfg_wdata_i),
        .prio_o  (prio_tab),
        .tgt_o   (tgt_tab),
        .pend_o  (pend)
    );

    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        intc_arb #(.N_SRC(N_SRC), .TGT_BIT(1'(t))) u_arb (
            .clk    (clk),
            .rst    (rst),
            .pend_i (pend),
            .prio_i (prio_tab),
            .tgt_i  (tgt_tab),
            .cur_i  (cur[t]),
            .win_o  (win[t])
        );

        intc_prio_stack #(.DEPTH(STK_DEPTH)) u_stk (
            .clk      (clk),
            .rst      (rst),
            .wr_cur_i (wr_cur_v[t]),
            .wr_val_i (cfg_wdata_i[PRIO_W-1:0]),
            .ack_i    (ack_v[t]),
            .eoi_i    (eoi_v[t]),
            .win_i    (win[t]),
            .cur_o    (cur[t]),
            .depth_o  (stk_depth[t])
        );
    end

    assign cpu_req_o      = win[0].valid;
    assign cpu_vec_o      = win[0].vec;
    assign cpu_cur_prio_o = cur[0];
    assign iop_req_o      = win[1].valid;
    assign iop_vec_o      = win[1].vec;
    assign iop_cur_prio_o = cur[1];
    assign cpu_crit_o     = crit_i;

endmodule

// File: rtl/intc_steer_chk.sv
module intc_steer_chk #(
    parameter int N_LIVE    = 294,
    parameter int STK_DEPTH = 16,
    parameter int DW        = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [1:0]    cfg_sel,
    input logic          cpu_req,
    input logic [8:0]    cpu_vec,
    input logic          iop_req,
    input logic [8:0]    iop_vec,
    input logic          cpu_ack,
    input logic          cpu_eoi,
    input logic          iop_ack,
    input logic          iop_eoi,
    input logic [DW-1:0] cpu_depth,
    input logic [DW-1:0] iop_depth
);
    logic cpu_wr, iop_wr;
    assign cpu_wr = cfg_we && (cfg_sel == 2'd2);
    assign iop_wr = cfg_we && (cfg_sel == 2'd3);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cpu_req && !iop_req && cpu_depth == '0 && iop_depth == '0));

    assert_steer_excl_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && iop_req) |-> (cpu_vec != iop_vec));

    assert_rsvd_cpu_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> (int'(cpu_vec) < N_LIVE));

    assert_rsvd_iop_R7: assert property (@(posedge clk) disable iff (rst)
        iop_req |-> (int'(iop_vec) < N_LIVE));

    assert_ack_push_cpu_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_ack && !cpu_wr && int'(cpu_depth) < STK_DEPTH)
        |=> (int'(cpu_depth) == int'($past(cpu_depth)) + 1));

    assert_ack_push_iop_R8: assert property (@(posedge clk) disable iff (rst)
        (iop_req && iop_ack && !iop_wr && int'(iop_depth) < STK_DEPTH)
        |=> (int'(iop_depth) == int'($past(iop_depth)) + 1));

    assert_eoi_pop_cpu_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_eoi && !cpu_ack && !cpu_wr && cpu_depth != '0)
        |=> (int'(cpu_depth) == int'($past(cpu_depth)) - 1));

    assert_eoi_pop_iop_R9: assert property (@(posedge clk) disable iff (rst)
        (iop_eoi && !iop_ack && !iop_wr && iop_depth != '0)
        |=> (int'(iop_depth) == int'($past(iop_depth)) - 1));

    assert_full_hold_cpu_R11: assert property (@(posedge clk) disable iff (rst)
        (int'(cpu_depth) == STK_DEPTH && cpu_ack && !cpu_wr)
        |=> (int'(cpu_depth) == STK_DEPTH));

    assert_depth_bound_R11: assert property (@(posedge clk) disable iff (rst)
        (int'(cpu_depth) <= STK_DEPTH) && (int'(iop_depth) <= STK_DEPTH));

endmodule

bind intc_steer_top intc_steer_chk #(
    .N_LIVE    (N_SRC - N_RSV),
    .STK_DEPTH (STK_DEPTH),
    .DW        ($clog2(STK_DEPTH + 1))
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we_i),
    .cfg_sel   (cfg_sel_i),
    .cpu_req   (cpu_req_o),
    .cpu_vec   (cpu_vec_o),
    .iop_req   (iop_req_o),
    .iop_vec   (iop_vec_o),
    .cpu_ack   (cpu_ack_i),
    .cpu_eoi   (cpu_eoi_i),
    .iop_ack   (iop_ack_i),
    .iop_eoi   (iop_eoi_i),
    .cpu_depth (stk_depth[0]),
    .iop_depth (stk_depth[1])
);

// File: tb/tb_intc_steer_top.sv
module tb_intc_steer_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC      = 316;
    localparam int N_RSV      = 22;
    localparam int N_SW       = 8;
    localparam int DEPTH      = 16;
    localparam int N_LIVE     = N_SRC - N_RSV;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N_SRC-1:0] irq = '0;
    logic             crit = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_sel = '0;
    logic [8:0]       cfg_idx = '0;
    logic [4:0]       cfg_wdata = '0;
    logic             ack_c = 1'b0, eoi_c = 1'b0, ack_p = 1'b0, eoi_p = 1'b0;
    logic             req_c, req_p, crit_o;
    logic [8:0]       vec_c, vec_p;
    logic [3:0]       cur_c, cur_p;

    int checks = 0;
    int errors = 0;

    int m_prio [N_SRC];
    int m_tgt  [N_SRC];
    int m_sw   [N_SW];
    int m_cur  [2];
    int m_stk  [2][DEPTH];
    int m_dep  [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_steer_top #(.N_SRC(N_SRC), .N_RSV(N_RSV), .N_SW(N_SW), .STK_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .irq_i(irq), .crit_i(crit),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
        .cpu_ack_i(ack_c), .cpu_eoi_i(eoi_c), .iop_ack_i(ack_p), .iop_eoi_i(eoi_p),
        .cpu_req_o(req_c), .cpu_vec_o(vec_c), .cpu_cur_prio_o(cur_c), .cpu_crit_o(crit_o),
        .iop_req_o(req_p), .iop_vec_o(vec_p), .iop_cur_prio_o(cur_p)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    function automatic void exp_win(int t, output int v, output int vec, output int p);
        v = 0; vec = 0; p = 0;
        for (int i = 0; i < N_SRC; i++) begin
            int pend;
            if (i < N_SW)        pend = m_sw[i];
            else if (i >= N_LIVE) pend = 0;
            else                 pend = int'(irq[i]);
            if (pend != 0 && m_tgt[i] == t && m_prio[i] > m_cur[t] && (v == 0 || m_prio[i] > p)) begin
                v = 1; vec = i; p = m_prio[i];
            end
        end
    endfunction

    task automatic check_all(string r);
        int v, vec, p;
        exp_win(0, v, vec, p);
        chk(r, "cpu req", int'(req_c), v);
        if (v != 0) chk(r, "cpu vec", int'(vec_c), vec);
        chk(r, "cpu cur", int'(cur_c), m_cur[0]);
        exp_win(1, v, vec, p);
        chk(r, "iop req", int'(req_p), v);
        if (v != 0) chk(r, "iop vec", int'(vec_p), vec);
        chk(r, "iop cur", int'(cur_p), m_cur[1]);
    endtask

    // drive a write, let it land, then let outputs follow
    task automatic cfg_write(int sel, int idx, int data);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = 9'(idx); cfg_wdata = 5'(data);
        tick();
        cfg_we = 1'b0;
        if (sel == 0 && idx < N_SRC) begin m_prio[idx] = data & 15; m_tgt[idx] = (data >> 4) & 1; end
        if (sel == 1 && idx < N_SW) m_sw[idx] = data & 1;
        if (sel == 2) m_cur[0] = data & 15;
        if (sel == 3) m_cur[1] = data & 15;
        tick();
    endtask

    task automatic set_irq(int idx, int val);
        irq[idx] = val[0];
        tick();
    endtask

    task automatic do_ack(int t, string r);
        int v, vec, p;
        exp_win(t, v, vec, p);
        if (t == 0) ack_c = 1'b1; else ack_p = 1'b1;
        tick();
        ack_c = 1'b0; ack_p = 1'b0;
        if (v != 0 && m_dep[t] < DEPTH) begin
            m_stk[t][m_dep[t]] = m_cur[t];
            m_dep[t]++;
            m_cur[t] = p;
        end
        chk(r, "cur after ack", int'((t == 0) ? cur_c : cur_p), m_cur[t]);
        tick();
        check_all(r);
    endtask

    task automatic do_eoi(int t, string r);
        if (t == 0) eoi_c = 1'b1; else eoi_p = 1'b1;
        tick();
        eoi_c = 1'b0; eoi_p = 1'b0;
        if (m_dep[t] > 0) begin
            m_dep[t]--;
            m_cur[t] = m_stk[t][m_dep[t]];
        end
        chk(r, "cur after eoi", int'((t == 0) ? cur_c : cur_p), m_cur[t]);
        tick();
        check_all(r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N_SRC; i++) begin m_prio[i] = 0; m_tgt[i] = 0; end
        for (int i = 0; i < N_SW; i++) m_sw[i] = 0;
        for (int t = 0; t < 2; t++) begin m_cur[t] = 0; m_dep[t] = 0; end

        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state
        chk("R1", "cpu req", int'(req_c), 0);
        chk("R1", "iop req", int'(req_p), 0);
        chk("R1", "cpu cur", int'(cur_c), 0);
        chk("R1", "iop cur", int'(cur_p), 0);

        // R10: critical line follows in the same cycle
        crit = 1'b1; #1;
        chk("R10", "crit high", int'(crit_o), 1);
        crit = 1'b0; #1;
        chk("R10", "crit low", int'(crit_o), 0);

        // R2: latency and vector identity
        cfg_write(0, 20, 5);
        irq[20] = 1'b1; #1;
        chk("R2", "req before edge", int'(req_c), 0);
        tick();
        chk("R2", "req after edge", int'(req_c), 1);
        chk("R2", "vec", int'(vec_c), 20);

        // R4: steering to the coprocessor
        cfg_write(0, 30, 16 + 5);
        set_irq(30, 1);
        check_all("R4");

        // R3: tie goes to the lower index, higher level wins
        cfg_write(0, 10, 5);
        set_irq(10, 1);
        check_all("R3");
        chk("R3", "tie vec", int'(vec_c), 10);
        cfg_write(0, 40, 9);
        set_irq(40, 1);
        chk("R3", "higher vec", int'(vec_c), 40);

        // R5: strict ceiling
        cfg_write(2, 0, 9);
        chk("R5", "equal level blocked", int'(req_c), 0);
        cfg_write(2, 0, 8);
        check_all("R5");

        // R6: hardware input on a software slot is ignored
        cfg_write(0, 3, 12);
        set_irq(3, 1);
        check_all("R6");
        chk("R6", "irq on sw slot ignored", int'(vec_c), 40);
        cfg_write(1, 3, 1);
        chk("R6", "sw flag vec", int'(vec_c), 3);
        cfg_write(1, 3, 0);
        check_all("R6");

        // R7: reserved source never requests
        cfg_write(0, 300, 15);
        set_irq(300, 1);
        check_all("R7");
        chk("R7", "reserved vec", int'(vec_c), 40);

        // R8, R9: ack, ack without request, eoi, eoi on empty
        do_ack(0, "R8");
        chk("R8", "raised cur", int'(cur_c), 9);
        do_ack(0, "R8");
        do_eoi(0, "R9");
        chk("R9", "popped cur", int'(cur_c), 8);
        do_eoi(0, "R9");

        // R11: full stack ignores ack, write beats ack
        for (int k = 0; k < DEPTH; k++) begin
            cfg_write(2, 0, k % 8);
            do_ack(0, "R11");
        end
        cfg_write(2, 0, 3);
        do_ack(0, "R11");
        chk("R11", "full ack ignored", int'(cur_c), 3);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 5'd1; ack_c = 1'b1;
        tick();
        cfg_we = 1'b0; ack_c = 1'b0; m_cur[0] = 1;
        chk("R11", "write beats ack", int'(cur_c), 1);
        tick();
        check_all("R11");
        for (int k = 0; k < DEPTH + 1; k++) do_eoi(0, "R9");

        // random phase
        void'($urandom(32'd2024));
        for (int i = 0; i < N_SRC; i++) cfg_write(0, i, int'($urandom_range(31, 0)));
        for (int t = 0; t < 2; t++) cfg_write(2 + t, 0, int'($urandom_range(6, 0)));
        for (int n = 0; n < 300; n++) begin
            int op = int'($urandom_range(9, 0));
            case (op)
                0, 1, 2: begin set_irq(int'($urandom_range(N_SRC - 1, 0)), int'($urandom_range(1, 0))); check_all("R3"); end
                3: begin cfg_write(0, int'($urandom_range(N_SRC - 1, 0)), int'($urandom_range(31, 0))); check_all("R4"); end
                4: begin cfg_write(1, int'($urandom_range(N_SW - 1, 0)), int'($urandom_range(1, 0))); check_all("R6"); end
                5: begin cfg_write(2 + int'($urandom_range(1, 0)), 0, int'($urandom_range(15, 0))); check_all("R5"); end
                6, 7: do_ack(int'($urandom_range(1, 0)), "R8");
                default: do_eoi(int'($urandom_range(1, 0)), "R9");
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule